// File: doc/BRIEF.md
# Eight-bit GPIO port with pull-up control

This block is the register and control side of a general-purpose I/O port with eight pins. Three registers sit behind a one-cycle register bus: a direction register, an output latch, and a pin-sampling address. Each bit of the direction register picks whether its pin is an input or an output. For each pin the block drives three signals to the pad: an output enable, an output level and a pull-up enable.

The output latch has two roles. On an output pin it sets the level the pin drives. On an input pin it turns the pull-up on or off. A global pull-up disable input can force off every pull-up in the port. The external pin levels pass through a two-stage synchronizer and can be read at the pin-sampling address. A write of ones to that address inverts the matching latch bits. Software can therefore flip single pins without a read-modify-write.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register and the output latch are all zeros. With the pull-up disable low, oe_o, out_o and pu_o are all zero, so every pin is a tri-state input.
- R2: oe_o equals the direction register bit by bit. out_o equals the output latch, so an output pin drives high when its latch bit is 1 and low when it is 0.
- R3: A write with addr_i = 1 stores wdata_i in the direction register. A write with addr_i = 2 stores wdata_i in the output latch. Reads at these two addresses return the stored register contents and never the pin levels.
- R4: A write with addr_i = 0 inverts every output-latch bit whose wdata_i bit is 1 and leaves the bits whose wdata_i bit is 0 unchanged. The direction bit has no effect on this, and the direction register is not changed.
- R5: pu_o for a pin is 1 exactly when its direction bit is 0, its latch bit is 1 and pud_i is 0. An output pin never has its pull-up enabled.
- R6: While pud_i is 1, every bit of pu_o is 0, whatever the register contents.
- R7: A read with addr_i = 0 returns pin_i as it was two clock edges earlier, through a two-stage synchronizer. This holds whatever the direction bits are.
- R8: A read with addr_i = 3 returns zero. A write to addr_i = 3 changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 pin sample/toggle, 1 direction, 2 output latch, 3 unused |
| wr_en_i | input | 1 | Write strobe, taken at the rising clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, available in the same cycle |
| pud_i | input | 1 | Global pull-up disable |
| pin_i | input | 8 | Asynchronous pin levels from the pads |
| oe_o | output | 8 | Per-pin output enable |
| out_o | output | 8 | Per-pin output level |
| pu_o | output | 8 | Per-pin pull-up enable |

## Verification
The bench drives a sweep of direction/latch pairs built from different arithmetic strides, and it repeats the sweep with the pull-up disable low and then high. This separates the pull-up gating from the output-enable path. Toggle masks go over latch contents with mixed direction bits, which shows that inversion depends only on the mask. Two step-by-step pin walks are checked at every step. The first goes from tri-state to output high through the pull-up state. The second goes from pull-up input to output low through tri-state. Walking-one pin patterns are sampled one and two edges after they change, which pins down the synchronizer delay with every pin both an input and an output.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PIN  = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_LAT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] lat_o
);
  logic [W-1:0] dir_q, lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      lat_q <= '0;
    end else if (wr_en_i) begin
      unique case (sel_i)
        SEL_DIR: dir_q <= wdata_i;
        SEL_LAT: lat_q <= wdata_i;
        SEL_PIN: lat_q <= lat_q ^ wdata_i;  // toggle by mask
        default: ;
      endcase
    end
  end

  assign dir_o = dir_q;
  assign lat_o = lat_q;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] lat_i,
  input  logic         pud_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pu_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign oe_o[b]  = dir_i[b];
    assign out_o[b] = lat_i[b];
    // latch bit doubles as pull-up request on inputs
    assign pu_o[b]  = ~dir_i[b] & lat_i[b] & ~pud_i;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned W          = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic              pud_i,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      oe_o,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      pu_o
);
  reg_sel_e     sel;
  logic [W-1:0] dir, lat, pin_sync;

  assign sel = reg_sel_e'(addr_i);

  gpio_sync #(.W(W), .STAGES(SYNC_DEPTH)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_regs #(.W(W)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .sel_i  (sel),
    .wdata_i(wdata_i),
    .dir_o  (dir),
    .lat_o  (lat)
  );

  gpio_pad_ctrl #(.W(W)) i_pad (
    .dir_i(dir),
    .lat_i(lat),
    .pud_i(pud_i),
    .oe_o (oe_o),
    .out_o(out_o),
    .pu_o (pu_o)
  );

  always_comb begin
    unique case (sel)
      SEL_PIN: rdata_o = pin_sync;
      SEL_DIR: rdata_o = dir;
      SEL_LAT: rdata_o = lat;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   addr_i,
  input logic         wr_en_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] rdata_o,
  input logic         pud_i,
  input logic [W-1:0] pin_i,
  input logic [W-1:0] oe_o,
  input logic [W-1:0] out_o,
  input logic [W-1:0] pu_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  a_r3_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1) |=> (oe_o == $past(wdata_i)));

  a_r3_lat_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2) |=> (out_o == $past(wdata_i)));

  a_r4_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0) |=> (out_o == ($past(out_o) ^ $past(wdata_i))) && $stable(oe_o));

  a_r5_no_pu_on_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o & pu_o) == '0);

  a_r6_pud_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pud_i |-> (pu_o == '0));

  a_r7_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && addr_i == 2'd0) |-> (rdata_o == $past(pin_i, 2)));

  a_r8_unused_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd3) |=> ($stable(oe_o) && $stable(out_o)));
endmodule

bind gpio_port gpio_port_chk #(.W(W)) i_gpio_port_chk (.*);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       pud_i = 1'b0;
  logic [7:0] pin_i = '0;
  logic [7:0] oe_o, out_o, pu_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_dir = '0, m_lat = '0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  gpio_port i_gpio_port (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    case (a)
      2'd0: m_lat = m_lat ^ d;
      2'd1: m_dir = d;
      2'd2: m_lat = d;
      default: ;
    endcase
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic chk_pads(string req);
    chk({req, " oe"}, oe_o, m_dir);
    chk({req, " out"}, out_o, m_lat);
    chk({req, " pu"}, pu_o, ~m_dir & m_lat & {8{~pud_i}});
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk_pads("R1");
    rd(2'd1, v); chk("R1 dir reg", v, 8'h00);
    rd(2'd2, v); chk("R1 lat reg", v, 8'h00);

    // R2/R3/R5/R6 sweep of dir/latch pairs under both pud values
    for (int p = 0; p < 2; p++) begin
      pud_i = p[0];
      for (int i = 0; i < 24; i++) begin
        wr(2'd1, 8'((i * 37 + 5) & 8'hff));
        wr(2'd2, 8'((i * 91 + 3) & 8'hff));
        chk_pads(p ? "R6" : "R2 R5");
        rd(2'd1, v); chk("R3 dir readback", v, m_dir);
        rd(2'd2, v); chk("R3 lat readback", v, m_lat);
      end
    end
    pud_i = 1'b0;

    // R4 toggle masks with mixed direction
    for (int i = 0; i < 16; i++) begin
      wr(2'd1, 8'((i * 53) & 8'hff));
      wr(2'd2, 8'((i * 29 + 7) & 8'hff));
      wr(2'd0, 8'((i * 71 + 1) & 8'hff));
      chk_pads("R4");
      rd(2'd1, v); chk("R4 dir untouched", v, m_dir);
    end
    wr(2'd0, 8'h00);
    chk_pads("R4 zero mask");

    // R8 unused address
    wr(2'd3, 8'hff);
    chk_pads("R8 write ignored");
    rd(2'd3, v); chk("R8 read zero", v, 8'h00);

    // R5 walk: tri-state -> pull-up -> output high (pin 3)
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    chk_pads("R5 walk tri");
    wr(2'd2, 8'h08); chk_pads("R5 walk pullup");
    chk("R5 pin3 pu on", pu_o & 8'h08, 8'h08);
    wr(2'd1, 8'h08); chk_pads("R5 walk out high");
    chk("R5 pin3 pu off", pu_o & 8'h08, 8'h00);
    // pull-up -> tri-state -> output low
    wr(2'd1, 8'h00); chk_pads("R5 walk back pullup");
    wr(2'd0, 8'h08); chk_pads("R4 walk tri");
    wr(2'd1, 8'h08); chk_pads("R2 walk out low");
    chk("R2 pin3 low", out_o & 8'h08, 8'h00);

    // R7 synchronizer delay, walking one, with dir all in then all out
    for (int d = 0; d < 2; d++) begin
      wr(2'd1, d ? 8'hff : 8'h00);
      for (int b = 0; b < 8; b++) begin
        logic [7:0] prev;
        @(negedge clk_i);
        prev = pin_i;
        pin_i = 8'(1 << b) ^ (d ? 8'hff : 8'h00);
        rd(2'd0, v); chk("R7 before edge", v, prev);
        @(negedge clk_i);
        rd(2'd0, v); chk("R7 one edge", v, prev);
        @(negedge clk_i);
        rd(2'd0, v); chk("R7 two edges", v, pin_i);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule